// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a bus host read and write a bank of sixteen 8-bit registers. It synchronises the SCL and SDA inputs to the system clock and finds START, repeated START and STOP from their edges. It drives SDA only through an enable that pulls the line low. Outside the block, a pull-up and the wired-AND of all devices form the line level.

After a START the block collects an address byte. If the upper seven bits equal the fixed target address 1010001, the block acknowledges. In a write, the first data byte sets the register pointer and each later byte goes to the bank through a one-cycle write strobe. A read uses a write to set the pointer, then a repeated START and the address with the read bit set. The block then sends the pointed register, most significant bit first, for as long as the host acknowledges.

The pointer advances after every byte moved in either direction and wraps from the last register to the first. A slow tick input gives the time base. If a transaction is still open after a set number of ticks, the block drops back to idle and releases SDA.

Top module: `i2cRegTarget`

## Requirements
- R1: After reset the block releases SDA (sdaOe low) and does not assert regWe.
- R2: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) returns the block to idle at any point, including in the middle of a byte, and a byte cut off this way is not written.
- R3: The block acknowledges only an address byte whose bits 7..1 equal 1010001. After any other address it sends no acknowledge, writes nothing and ignores the bus until the next START or STOP.
- R4: For every byte it receives after a matching address, the block pulls SDA low during the 9th SCL pulse. It starts pulling SDA low only while SCL is low.
- R5: In a write transfer (address bit 0 = 0), bits 3..0 of the first data byte load the register pointer, and each later byte is written to the register at the pointer.
- R6: The pointer increments after each byte written or sent and wraps from 0Fh to 00h.
- R7: After a repeated START and an address with bit 0 = 1, the block sends the register at the pointer, MSB first, and sends the next register after each host ACK (SDA low on the 9th pulse).
- R8: When the host answers a sent byte with NACK (SDA high on the 9th pulse), the block keeps SDA released until the next START or STOP.
- R9: If TIMEOUT_TICKS pulses of timeoutTick arrive between a START from idle and the closing STOP, the block goes idle and releases SDA. A repeated START does not restart this count.
- R10: regWe is high for exactly one clock cycle for each byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| timeoutTick | input | 1 | One-cycle pulse of the transaction time base |
| regAddr | output | 4 | Register pointer presented to the bank |
| regWdata | output | 8 | Byte to write into the bank |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Contents of the register at regAddr |

## Verification
The embedded assertions check the following on every cycle:
- the SDA pull starts only while SCL is low;
- a STOP or an expired time window leaves the block idle with SDA released;
- a START always reopens address reception;
- the bit counter stays within a byte plus its acknowledge;
- the pointer steps by one and wraps;
- the write strobe never lasts two cycles.

Only the bench scenarios can show that whole bytes land in the right registers and that the pointer survives a repeated START into a read. They also show that a foreign address or a STOP part-way through a byte leaves the bank untouched, and that after a host NACK the line reads all ones.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } tgtState_t;

  typedef struct packed {
    logic clrBits;
    logic loadPtr;
    logic incPtr;
    logic wrEn;
    logic loadTx;
    logic shiftTx;
    logic busy;
  } ctrlStrb_t;

endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter int TIMEOUT_TICKS = 1000,
  localparam int PTR_W        = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             tick,
  input  ctrlStrb_t        strb,
  input  logic [6:0]       rdLow,
  output logic             sclNow,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic             timeoutHit,
  output logic [3:0]       bitCnt,
  output logic [7:0]       rxByte,
  output logic             txNext,
  output logic [PTR_W-1:0] ptr
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_REGS - 1);

  logic [1:0]       sclSync, sdaSync;
  logic             sclPrev, sdaPrev, sdaNow;
  logic [6:0]       txShift;
  logic [CNT_W-1:0] toutCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (strb.clrBits)  bitCnt <= '0;
      else if (sclRise)  bitCnt <= bitCnt + 4'd1;
      if (sclRise)       rxByte <= {rxByte[6:0], sdaNow};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '0;
    else if (strb.loadTx)  txShift <= rdLow;
    else if (strb.shiftTx) txShift <= {txShift[5:0], 1'b0};
  end
  assign txNext = txShift[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ptr <= '0;
    else if (strb.loadPtr) ptr <= rxByte[PTR_W-1:0];
    else if (strb.incPtr)  ptr <= (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          toutCnt <= '0;
    else if (!strb.busy) toutCnt <= '0;
    else if (tick)       toutCnt <= toutCnt + 1'b1;
  end
  assign timeoutHit = strb.busy & tick & (toutCnt == CNT_W'(TIMEOUT_TICKS - 1));

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPtr && !strb.loadPtr && ptr == PTR_MAX |=> ptr == '0); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPtr && !strb.loadPtr && ptr != PTR_MAX |=> ptr == $past(ptr) + 1'b1); // R6
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9); // R4

endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1010001
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclNow,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      timeoutHit,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic      txNext,
  input  logic      rdMsb,
  output ctrlStrb_t strb,
  output logic      sdaDrive
);

  tgtState_t state, stNext;
  logic      readDir, dirNext, drvNext;
  logic      active;

  assign active = (state == ST_ADDR) || (state == ST_PTR) ||
                  (state == ST_WDATA) || (state == ST_RDATA);

  always_comb begin
    stNext       = state;
    drvNext      = sdaDrive;
    dirNext      = readDir;
    strb         = '0;
    strb.busy    = (state != ST_IDLE);
    strb.clrBits = !active;
    if (timeoutHit || stopDet) begin
      stNext  = ST_IDLE;
      drvNext = 1'b0;
    end else if (startDet) begin
      stNext       = ST_ADDR;
      drvNext      = 1'b0;
      strb.clrBits = 1'b1;
    end else if (sclFall && active) begin
      if (bitCnt == 4'd8) begin
        case (state)
          ST_ADDR: begin
            if (rxByte[7:1] == TGT_ADDR) begin
              drvNext = 1'b1;
              dirNext = rxByte[0];
            end else begin
              stNext  = ST_WAIT;
              drvNext = 1'b0;
            end
          end
          ST_PTR: begin
            strb.loadPtr = 1'b1;
            drvNext      = 1'b1;
          end
          ST_WDATA: begin
            strb.wrEn   = 1'b1;
            strb.incPtr = 1'b1;
            drvNext     = 1'b1;
          end
          default: drvNext = 1'b0;
        endcase
      end else if (bitCnt == 4'd9) begin
        strb.clrBits = 1'b1;
        drvNext      = 1'b0;
        case (state)
          ST_ADDR: begin
            if (readDir) begin
              stNext      = ST_RDATA;
              strb.loadTx = 1'b1;
              strb.incPtr = 1'b1;
              drvNext     = !rdMsb;
            end else begin
              stNext = ST_PTR;
            end
          end
          ST_PTR: stNext = ST_WDATA;
          ST_RDATA: begin
            if (!rxByte[0]) begin
              strb.loadTx = 1'b1;
              strb.incPtr = 1'b1;
              drvNext     = !rdMsb;
            end else begin
              stNext = ST_WAIT;
            end
          end
          default: ;
        endcase
      end else if (state == ST_RDATA && bitCnt != 4'd0) begin
        strb.shiftTx = 1'b1;
        drvNext      = !txNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sdaDrive <= 1'b0;
      readDir  <= 1'b0;
    end else begin
      state    <= stNext;
      sdaDrive <= drvNext;
      readDir  <= dirNext;
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrive) |-> !sclNow); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> state == ST_IDLE && !sdaDrive); // R2
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startDet && !timeoutHit |=> state == ST_ADDR); // R2
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> state == ST_IDLE && !sdaDrive); // R9
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT |-> !strb.wrEn && !sdaDrive); // R3

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter int         NUM_REGS      = 16,
  parameter int         TIMEOUT_TICKS = 1000,
  parameter logic [6:0] TGT_ADDR      = 7'b1010001,
  localparam int        PTR_W         = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic             timeoutTick,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWdata,
  output logic             regWe,
  input  logic [7:0]       regRdata
);

  ctrlStrb_t  strb;
  logic       sclNow, sclRise, sclFall, startDet, stopDet, timeoutHit, txNext;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  i2cTgtDatapath #(
    .NUM_REGS(NUM_REGS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .tick(timeoutTick),
    .strb(strb), .rdLow(regRdata[6:0]), .sclNow(sclNow), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .timeoutHit(timeoutHit), .bitCnt(bitCnt), .rxByte(rxByte),
    .txNext(txNext), .ptr(regAddr)
  );

  i2cTgtControl #(
    .TGT_ADDR(TGT_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .sclNow(sclNow), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .timeoutHit(timeoutHit),
    .bitCnt(bitCnt), .rxByte(rxByte), .txNext(txNext), .rdMsb(regRdata[7]),
    .strb(strb), .sdaDrive(sdaOe)
  );

  assign regWdata = rxByte;
  assign regWe    = strb.wrEn;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R10

endmodule

// File: tb/i2cRegTarget_tb.sv
module i2cRegTarget_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int TICKS      = 4;
  localparam logic [6:0] TA = 7'b1010001;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostScl = 1'b1, hostSda = 1'b1, tick = 1'b0;
  logic sdaOe, regWe;
  logic [3:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic busSda;
  logic [7:0] bank [16];
  logic [7:0] expMem [16];
  int checks = 0, errors = 0, weCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busSda   = hostSda & ~sdaOe;
  assign regRdata = bank[regAddr];

  i2cRegTarget #(.TIMEOUT_TICKS(TICKS)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(busSda), .sdaOe(sdaOe),
    .timeoutTick(tick), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (regWe) begin
      bank[regAddr] <= regWdata;
      weCnt <= weCnt + 1;
    end
  end

  function automatic logic [3:0] wrapIdx(input logic [3:0] p, input int i);
    return 4'((int'(p) + i) % 16);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic hStart();
    hostSda = 1'b1; hostScl = 1'b1; waitQ();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic hRestart();
    hostSda = 1'b1; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic hStop();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b1; waitQ();
  endtask

  task automatic hBit(input logic b, output logic r);
    hostSda = b; waitQ();
    hostScl = 1'b1; waitQ();
    r = busSda;
    hostScl = 1'b0; waitQ();
  endtask

  task automatic hSend(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) hBit(d[i], r);
    hBit(1'b1, ack);
  endtask

  task automatic hRecv(input logic giveAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin hBit(1'b1, r); d[i] = r; end
    hBit(!giveAck, r);
  endtask

  task automatic writeSeq(input logic [3:0] p, input logic [7:0] d [4], input int n);
    logic a;
    int w0 = weCnt;
    hStart();
    hSend({TA, 1'b0}, a); check("R3 addr ack", a, 0);
    hSend({4'h0, p}, a);  check("R4 ptr ack", a, 0);
    for (int i = 0; i < n; i++) begin
      hSend(d[i], a); check("R4 data ack", a, 0);
      expMem[wrapIdx(p, i)] = d[i];
    end
    hStop();
    check("R10 strobes", weCnt - w0, n);
  endtask

  task automatic readSeq(input logic [3:0] p, input int n, input string req);
    logic a;
    logic [7:0] d;
    hStart();
    hSend({TA, 1'b0}, a); check("R3 addr ack", a, 0);
    hSend({4'h0, p}, a);  check("R5 ptr ack", a, 0);
    hRestart();
    hSend({TA, 1'b1}, a); check("R7 read addr ack", a, 0);
    for (int i = 0; i < n; i++) begin
      hRecv(i != n - 1, d);
      check(req, d, expMem[wrapIdx(p, i)]);
    end
    hStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] buf4 [4];
    int unsigned seedV;
    int w0;
    for (int i = 0; i < 16; i++) begin bank[i] = 8'h00; expMem[i] = 8'h00; end
    seedV = 32'd20240601;
    void'($urandom(seedV));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 sdaOe after reset", sdaOe, 0);
    check("R1 regWe after reset", regWe, 0);

    // R5 R10: directed write of three bytes at pointer 2
    buf4[0] = 8'hA5; buf4[1] = 8'h3C; buf4[2] = 8'h7E; buf4[3] = 8'h00;
    writeSeq(4'h2, buf4, 3);
    // R7 R8: read back with final NACK, then extra byte reads as all ones
    hStart();
    hSend({TA, 1'b0}, a); hSend(8'h02, a);
    hRestart();
    hSend({TA, 1'b1}, a); check("R7 read addr ack", a, 0);
    hRecv(1'b1, d); check("R7 read byte0", d, 8'hA5);
    hRecv(1'b1, d); check("R7 read byte1", d, 8'h3C);
    hRecv(1'b0, d); check("R7 read byte2", d, 8'h7E);
    hRecv(1'b0, d); check("R8 released after NACK", d, 8'hFF);
    hStop();

    // R6: write and read across the wrap
    buf4[0] = 8'h11; buf4[1] = 8'h22; buf4[2] = 8'h33;
    writeSeq(4'hE, buf4, 3);
    readSeq(4'hF, 2, "R6 wrap read");

    // R3: foreign address is ignored
    w0 = weCnt;
    hStart();
    hSend({7'b1010010, 1'b0}, a); check("R3 foreign addr nack", a, 1);
    hSend(8'h05, a); check("R3 no ack after foreign", a, 1);
    hSend(8'hEE, a); check("R3 no ack data", a, 1);
    hStop();
    check("R3 no write on foreign", weCnt - w0, 0);

    // R2: STOP in the middle of a data byte
    w0 = weCnt;
    hStart();
    hSend({TA, 1'b0}, a); hSend(8'h05, a);
    for (int i = 0; i < 4; i++) hBit(1'b0, a);
    hStop();
    check("R2 partial byte not written", weCnt - w0, 0);
    readSeq(4'h5, 1, "R2 bank intact");

    // R9: fewer ticks than the window keep the transfer open
    hStart();
    hSend({TA, 1'b0}, a);
    for (int i = 0; i < TICKS - 1; i++) begin tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk); end
    hSend(8'h07, a); check("R9 ack before window ends", a, 0);
    hStop();
    // R9: full window aborts the transfer
    w0 = weCnt;
    hStart();
    hSend({TA, 1'b0}, a); hSend(8'h08, a);
    hostSda = 1'b1;
    for (int i = 0; i < TICKS; i++) begin tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk); end
    repeat (3) @(negedge clk);
    check("R9 SDA released on timeout", sdaOe, 0);
    hSend(8'h99, a); check("R9 no ack after timeout", a, 1);
    hStop();
    check("R9 no write after timeout", weCnt - w0, 0);

    // random bursts (R5 R6 R7)
    for (int it = 0; it < 16; it++) begin
      logic [3:0] p;
      int n;
      p = 4'($urandom_range(0, 15));
      n = int'($urandom_range(1, 4));
      for (int i = 0; i < 4; i++) buf4[i] = 8'($urandom);
      writeSeq(p, buf4, n);
      p = 4'($urandom_range(0, 15));
      readSeq(p, int'($urandom_range(1, 4)), "R7 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule